// File: doc/BRIEF.md
# DMA Peripheral-Side Flow-Control Requester

This block lives inside a peripheral that controls the flow of a DMA block transfer. Software or neighbouring logic loads the number of data items in the block and a burst length with a start pulse. The block then asks the DMA controller for transactions over a request/acknowledge handshake, one transaction at a time. Each request carries two qualifiers. A single qualifier marks a one-item transaction. A last qualifier marks the transaction that closes the block. This lets the peripheral, not the controller, decide where the block ends.

While the items still to be moved are at least one burst, the block asks for a burst. A remainder smaller than one burst is moved as single-item transactions, one item each. When the block size is an exact multiple of the burst length, every transaction is a burst and the single qualifier never rises. A block can therefore mix burst and single transactions. A done pulse follows the acknowledge of the final transaction.

Top module: `dma_flow_req`

## Requirements
- R1: While rst_ni is low, and after its release with no start, req_o, single_o, last_o, done_o and busy_o are all low.
- R2: A start_i pulse with nonzero blk_items_i, seen at a clock edge while busy_o is low, loads the block. busy_o is high and req_o is high in the very next cycle.
- R3: Once req_o is high it stays high, with single_o and last_o unchanged, until a cycle in which ack_i is high. In the cycle after that acknowledge, req_o is low.
- R4: While the remaining item count is greater than or equal to the burst length, the request is a burst (single_o low) and its acknowledge removes one burst length of items.
- R5: While the remaining count is nonzero but below the burst length, each request has single_o high and its acknowledge removes exactly one item.
- R6: last_o is high with a request exactly when that transaction's acknowledge brings the remaining count to zero. This covers both the burst case and the single case.
- R7: single_o and last_o are low in every cycle in which req_o is low.
- R8: When blk_items_i is an exact multiple of the burst length, single_o never rises during that block.
- R9: done_o is a one-cycle pulse in the cycle after the acknowledge of the last-marked transaction. busy_o is low in that same cycle.
- R10: A start_i with blk_items_i equal to zero is ignored. busy_o and req_o stay low.
- R11: The burst length is 2 to the power of burst_code_i. Codes 9 to 15 are clamped to 8, which gives 256 items.
- R12: start_i while busy_o is high is ignored. The block in progress keeps its transaction sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load block size and burst code, begin requesting |
| blk_items_i | input | CNT_W | Items in the block |
| burst_code_i | input | 4 | log2 of burst length, clamped to 8 |
| ack_i | input | 1 | Acknowledge from the DMA controller |
| req_o | output | 1 | Transaction request |
| single_o | output | 1 | Request is a single-item transaction |
| last_o | output | 1 | Request closes the block |
| busy_o | output | 1 | Block in progress |
| done_o | output | 1 | One-cycle pulse after the final acknowledge |

## Verification
A model of the DMA controller answers each request after a varying latency. It compares the single and last qualifiers against a sequence predicted from the block size and burst length.

The patterns are chosen so that each one separates a different behaviour:
- Exact multiples separate pure-burst blocks from mixed ones.
- Remainders of one and of one-less-than-a-burst separate the point where bursts switch to singles.
- Blocks smaller than a burst produce singles only.
- A burst length of one produces one-item bursts that are not marked single.
- Clamped codes must match code 8.
- Zero-size starts and starts during a busy block check that those inputs are ignored.

// File: rtl/dfr_pkg.sv
package dfr_pkg;
  localparam int unsigned MAX_CODE = 8;
  localparam int unsigned LEN_W    = MAX_CODE + 1;
  localparam int unsigned CODE_W   = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_GAP  = 2'd2
  } req_state_e;
endpackage

// File: rtl/dfr_burst_cfg.sv
module dfr_burst_cfg
  import dfr_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic [LEN_W-1:0]  len_o
);
  logic [CODE_W-1:0] code_c;

  always_comb begin
    code_c = (code_i > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code_i;
    len_o  = LEN_W'(1) << code_c;
  end
endmodule

// File: rtl/dfr_item_cnt.sv
module dfr_item_cnt
  import dfr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] items_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             take_i,
  output logic             burst_o,
  output logic             last_o
);
  logic [CNT_W-1:0] remain_q;
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] step;

  always_comb begin
    burst_o = remain_q >= len_q;
    step    = burst_o ? len_q : CNT_W'(1);
    last_o  = remain_q == step;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remain_q <= '0;
      len_q    <= CNT_W'(1);
    end else if (load_i) begin
      remain_q <= items_i;
      len_q    <= CNT_W'(len_i);
    end else if (take_i) begin
      remain_q <= remain_q - step;
    end
  end
endmodule

// File: rtl/dfr_req_fsm.sv
module dfr_req_fsm
  import dfr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_ok_i,
  input  logic ack_i,
  input  logic last_i,
  output logic load_o,
  output logic take_o,
  output logic req_o,
  output logic busy_o,
  output logic done_o
);
  req_state_e state_q, state_d;
  logic       done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_ok_i) state_d = ST_REQ;
      ST_REQ:  if (ack_i) state_d = last_i ? ST_IDLE : ST_GAP;
      ST_GAP:  state_d = ST_REQ;
      default: state_d = ST_IDLE;
    endcase
  end

  assign load_o = (state_q == ST_IDLE) && start_ok_i;
  assign req_o  = state_q == ST_REQ;
  assign take_o = req_o && ack_i;
  assign busy_o = state_q != ST_IDLE;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= take_o && last_i;
    end
  end
endmodule

// File: rtl/dma_flow_req.sv
module dma_flow_req
  import dfr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  blk_items_i,
  input  logic [CODE_W-1:0] burst_code_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic              single_o,
  output logic              last_o,
  output logic              busy_o,
  output logic              done_o
);
  logic [LEN_W-1:0] len;
  logic             load, take, burst, cnt_last, start_ok, req;

  assign start_ok = start_i && (blk_items_i != '0);

  dfr_burst_cfg u_cfg (
    .code_i (burst_code_i),
    .len_o  (len)
  );

  dfr_item_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .items_i (blk_items_i),
    .len_i   (len),
    .take_i  (take),
    .burst_o (burst),
    .last_o  (cnt_last)
  );

  dfr_req_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_ok_i (start_ok),
    .ack_i      (ack_i),
    .last_i     (cnt_last),
    .load_o     (load),
    .take_o     (take),
    .req_o      (req),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  assign req_o    = req;
  assign single_o = req && !burst;
  assign last_o   = req && cnt_last;
endmodule

// File: rtl/dfr_checker.sv
module dfr_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [CNT_W-1:0] blk_items_i,
  input logic             ack_i,
  input logic             req_o,
  input logic             single_o,
  input logic             last_o,
  input logic             busy_o,
  input logic             done_o
);
  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(single_o) && $stable(last_o));
  // R3
  req_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && ack_i |=> !req_o);
  // R7
  qual_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o |-> !single_o && !last_o);
  // R9
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && ack_i && last_o |=> done_o && !busy_o);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10
  zero_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i && blk_items_i == '0 |=> !busy_o && !req_o);
  // R2
  start_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i && blk_items_i != '0 |=> req_o && busy_o);
endmodule

bind dma_flow_req dfr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .blk_items_i (blk_items_i),
  .ack_i       (ack_i),
  .req_o       (req_o),
  .single_o    (single_o),
  .last_o      (last_o),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/dma_flow_req_test.sv
module dma_flow_req_test;
  localparam int CNT_W = 16;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [CNT_W-1:0] blk_items_i = '0;
  logic [3:0]       burst_code_i = '0;
  logic             ack_i = 1'b0;
  logic             req_o, single_o, last_o, busy_o, done_o;

  int n_chk = 0;
  int n_bad = 0;
  int ack_dly = 0;
  int wait_cnt = 0;
  bit exp_done = 1'b0;
  bit mon_on = 1'b0;
  bit finished = 1'b0;
  logic [1:0] exp_q[$];  // {single, last}

  always #4 clk_i = ~clk_i;  // 125 MHz

  dma_flow_req #(.CNT_W(CNT_W)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .blk_items_i(blk_items_i), .burst_code_i(burst_code_i), .ack_i(ack_i),
    .req_o(req_o), .single_o(single_o), .last_o(last_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Predict transaction sequence from the requirements
  task automatic push_block(input int items, input int code);
    int len = 1 << ((code > 8) ? 8 : code);
    int rem = items;
    while (rem > 0) begin
      if (rem >= len) begin
        exp_q.push_back({1'b0, rem == len});  // R4 burst
        rem -= len;
      end else begin
        exp_q.push_back({1'b1, rem == 1});    // R5 single
        rem -= 1;
      end
    end
  endtask

  // Monitor / DMA controller model
  initial begin
    forever begin
      @(negedge clk_i);
      if (mon_on) begin
        if (exp_done) check(done_o && !busy_o, "R9", {done_o, busy_o}, 2);
        else if (done_o) check(1'b0, "R9", done_o, 0);
        exp_done = 1'b0;
        if (!req_o) check(!single_o && !last_o, "R7", {single_o, last_o}, 0);
        if (ack_i) begin
          ack_i = 1'b0;
          check(!req_o, "R3", req_o, 0);
        end else if (req_o) begin
          if (wait_cnt < ack_dly) wait_cnt++;
          else begin
            wait_cnt = 0;
            if (exp_q.size() == 0) check(1'b0, "R6", {single_o, last_o}, -1);
            else begin
              logic [1:0] e;
              e = exp_q.pop_front();
              check({single_o, last_o} == e, "R4/R5/R6", {single_o, last_o}, e);
              if (e[0]) exp_done = 1'b1;
            end
            ack_i = 1'b1;
          end
        end
      end
    end
  end

  task automatic run_block(input int items, input int code, input int dly,
                           input bit extra_start, input bit no_single);
    bit saw_single = 1'b0;
    ack_dly = dly;
    push_block(items, code);
    @(negedge clk_i);
    start_i = 1'b1; blk_items_i = CNT_W'(items); burst_code_i = 4'(code);
    @(negedge clk_i);
    start_i = 1'b0;
    check(req_o && busy_o, "R2", {req_o, busy_o}, 3);
    if (extra_start) begin
      @(negedge clk_i);
      start_i = 1'b1; blk_items_i = CNT_W'(3); burst_code_i = 4'd0;  // R12
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (busy_o) begin
      if (single_o) saw_single = 1'b1;
      @(negedge clk_i);
    end
    repeat (2) @(negedge clk_i);
    check(exp_q.size() == 0, extra_start ? "R12" : "R6", exp_q.size(), 0);
    check(!busy_o && !req_o, "R12", {busy_o, req_o}, 0);
    if (no_single) check(!saw_single, "R8", saw_single, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check({req_o, single_o, last_o, done_o, busy_o} == 5'b0, "R1",
          {req_o, single_o, last_o, done_o, busy_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check({req_o, single_o, last_o, done_o, busy_o} == 5'b0, "R1",
          {req_o, single_o, last_o, done_o, busy_o}, 0);
    mon_on = 1'b1;

    run_block(32, 3, 0, 1'b0, 1'b1);   // R8 exact multiple
    run_block(17, 2, 1, 1'b0, 1'b0);   // R5 remainder 1
    run_block(15, 3, 2, 1'b0, 1'b0);   // R4 burst then singles
    run_block(3, 2, 0, 1'b0, 1'b0);    // R5 singles only
    run_block(1, 0, 0, 1'b0, 1'b1);    // R4 one-item burst, not single
    run_block(5, 0, 3, 1'b0, 1'b1);    // R8 burst length 1
    run_block(600, 12, 0, 1'b0, 1'b0); // R11 clamp to 256
    run_block(600, 8, 1, 1'b0, 1'b0);  // R11 reference code 8
    run_block(64, 15, 0, 1'b0, 1'b0);  // R11 code 15 -> singles only
    run_block(40, 2, 2, 1'b1, 1'b1);   // R12 start while busy

    // R10 zero-size start
    @(negedge clk_i);
    start_i = 1'b1; blk_items_i = '0; burst_code_i = 4'd2;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (4) begin
      check(!busy_o && !req_o, "R10", {busy_o, req_o}, 0);
      @(negedge clk_i);
    end
    run_block(9, 1, 0, 1'b0, 1'b0);    // R2 still starts after ignored start

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule